// File: doc/BRIEF.md
# Relay-Style Latch with Qualified Edge Toggle

This block is one latch bit of the kind found in protective-relay control logic. It is evaluated once per processing interval. A strobe input marks each interval, and the stored bit and all history change only on a strobe. Between strobes every output holds its value. In latch mode the bit follows set and reset inputs. A build-time parameter chooses which of the two wins when both are asserted.

In toggle mode, which a static input selects, the set and reset inputs are ignored. The bit instead flips on each qualified edge of a separate toggle input. An optional pickup qualifier requires the toggle input to be sampled high at several consecutive strobes before its level counts as asserted. This suits a hold-to-operate pushbutton. The qualified level drops out at once when the input falls. A parameter selects whether rising or falling edges of the qualified level are detected. Each detected edge also appears on a pulse output that stays high for exactly one interval.

Synchronous reset clears the bit, the edge history, the pickup count and the pulse. This gives a known state after a power cycle.

Top module: `relayLatch`

## Requirements
- R1: While `rst` is high at a clock edge, `latchQ`, `edgePulse`, the edge history and the pickup count are all cleared. The first strobe after reset with the qualified toggle level high therefore counts as a rising edge.
- R2: `latchQ` and `edgePulse` change only at clock edges where `tick` is 1. At any other edge they keep their values.
- R3: With SET_DOM=0 (reset-dominant) and `togMode`=0, a strobe loads (setIn OR latchQ) AND NOT rstIn.
- R4: With SET_DOM=1 (set-dominant) and `togMode`=0, a strobe loads setIn OR (latchQ AND NOT rstIn).
- R5: With `togMode`=0, `togIn` has no effect on `latchQ`. Edges on `togIn` are still reported on `edgePulse`.
- R6: With `togMode`=1, `setIn` and `rstIn` are ignored, and each strobe that detects an edge inverts `latchQ`. A strobe without an edge leaves `latchQ` unchanged.
- R7: An edge is a change of the qualified toggle level between consecutive strobes. It raises `edgePulse` at that strobe, and `edgePulse` stays high until the next strobe clears it, so the pulse lasts exactly one interval.
- R8: With PICKUP_TICKS=N>1, the qualified level is 1 at a strobe only when `togIn` has been sampled 1 at that strobe and at the N-1 strobes before it. A shorter run of highs produces no edge. A strobe that samples 0 drops the level at once. With N≤1 the qualified level equals `togIn`.
- R9: With FALL_EDGE=1, edges are 1-to-0 changes of the qualified level instead of 0-to-1 changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Processing-interval strobe; one clock wide |
| setIn | input | 1 | Latch set request |
| rstIn | input | 1 | Latch reset request |
| togIn | input | 1 | Toggle pushbutton input |
| togMode | input | 1 | 1 selects toggle mode, 0 selects set/reset mode; held static |
| latchQ | output | 1 | Stored latch bit |
| edgePulse | output | 1 | High for one interval after each detected edge |

## Verification
A corrupt edge history produces a spurious or missing `edgePulse`, and in toggle mode a flipped `latchQ`, at the very next strobe. A pickup count off by one moves the toggle one strobe earlier or later. The bench catches this with runs of highs that are one strobe shorter than the pickup length and with runs that reach it exactly. A wrong dominance choice is visible at the first strobe that has both requests high. Any update that leaks between strobes shows up in the clock cycle where it happens, because the bench samples the outputs during idle gaps.

// File: rtl/relayLatchPkg.sv
package relayLatchPkg;

  // Strobes handed from the control half to the datapath half.
  typedef struct packed {
    logic tick;     // interval strobe: state may update this cycle
    logic edgeHit;  // qualified edge detected at this strobe
    logic togMode;  // toggle mode selected
  } latchCmd_t;

endpackage

// File: rtl/relayLatchCtrl.sv
module relayLatchCtrl
  import relayLatchPkg::*;
#(
  parameter int PICKUP_TICKS = 3,
  parameter bit FALL_EDGE    = 1'b0
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      togIn,
  input  logic      togMode,
  output latchCmd_t cmd,
  output logic      edgePulse
);

  logic qualLvl;   // toggle level after pickup qualification
  logic prevLvl;   // qualified level seen at the previous strobe
  logic edgeNow;
  logic pulseQ;

  // Pickup qualifier: counts prior consecutive high samples.
  generate
    if (PICKUP_TICKS > 1) begin : g_pickup
      localparam int CNT_W = $clog2(PICKUP_TICKS);
      localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PICKUP_TICKS - 1);
      logic [CNT_W-1:0] runCnt;

      always_ff @(posedge clk) begin
        if (rst) begin
          runCnt <= '0;
        end else if (tick) begin
          if (!togIn)
            runCnt <= '0;
          else if (runCnt != CNT_MAX)
            runCnt <= runCnt + 1'b1;
        end
      end

      assign qualLvl = togIn && (runCnt == CNT_MAX);
    end else begin : g_direct
      assign qualLvl = togIn;
    end
  endgenerate

  // Edge polarity chosen at build time.
  generate
    if (FALL_EDGE) begin : g_fall
      assign edgeNow = prevLvl && !qualLvl;
    end else begin : g_rise
      assign edgeNow = !prevLvl && qualLvl;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      prevLvl <= 1'b0;
      pulseQ  <= 1'b0;
    end else if (tick) begin
      prevLvl <= qualLvl;
      pulseQ  <= edgeNow;
    end
  end

  always_comb begin
    cmd.tick    = tick;
    cmd.edgeHit = tick && edgeNow;
    cmd.togMode = togMode;
  end

  assign edgePulse = pulseQ;

endmodule

// File: rtl/relayLatchPath.sv
module relayLatchPath
  import relayLatchPkg::*;
#(
  parameter bit SET_DOM = 1'b0
) (
  input  logic      clk,
  input  logic      rst,
  input  latchCmd_t cmd,
  input  logic      setIn,
  input  logic      rstIn,
  output logic      stateQ
);

  logic srNext;
  logic stateNext;

  generate
    if (SET_DOM) begin : g_setWins
      assign srNext = setIn | (stateQ & ~rstIn);
    end else begin : g_rstWins
      assign srNext = (setIn | stateQ) & ~rstIn;
    end
  endgenerate

  always_comb begin
    stateNext = stateQ;
    if (cmd.tick) begin
      if (cmd.togMode)
        stateNext = cmd.edgeHit ? ~stateQ : stateQ;
      else
        stateNext = srNext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      stateQ <= 1'b0;
    else
      stateQ <= stateNext;
  end

endmodule

// File: rtl/relayLatch.sv
module relayLatch
  import relayLatchPkg::*;
#(
  parameter bit SET_DOM      = 1'b0,
  parameter bit FALL_EDGE    = 1'b0,
  parameter int PICKUP_TICKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic setIn,
  input  logic rstIn,
  input  logic togIn,
  input  logic togMode,
  output logic latchQ,
  output logic edgePulse
);

  latchCmd_t cmd;

  relayLatchCtrl #(
    .PICKUP_TICKS(PICKUP_TICKS),
    .FALL_EDGE   (FALL_EDGE)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .togIn    (togIn),
    .togMode  (togMode),
    .cmd      (cmd),
    .edgePulse(edgePulse)
  );

  relayLatchPath #(
    .SET_DOM(SET_DOM)
  ) u_path (
    .clk   (clk),
    .rst   (rst),
    .cmd   (cmd),
    .setIn (setIn),
    .rstIn (rstIn),
    .stateQ(latchQ)
  );

endmodule

// File: rtl/relayLatchChk.sv
module relayLatchChk #(
  parameter bit SET_DOM = 1'b0
) (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic setIn,
  input logic rstIn,
  input logic togMode,
  input logic latchQ,
  input logic edgePulse
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!latchQ && !edgePulse));

  assert_hold_state_R2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(latchQ));

  assert_hold_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(edgePulse));

  generate
    if (SET_DOM) begin : g_setChk
      assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && !togMode && setIn) |=> latchQ);
      assert_reset_only_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && !togMode && !setIn && rstIn) |=> !latchQ);
    end else begin : g_rstChk
      assert_reset_wins_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && !togMode && rstIn) |=> !latchQ);
      assert_set_only_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && !togMode && setIn && !rstIn) |=> latchQ);
    end
  endgenerate

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (tick && !togMode && !setIn && !rstIn) |=> $stable(latchQ));

  assert_toggle_flip_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && togMode) |=> ((latchQ != $past(latchQ)) == edgePulse));

endmodule

bind relayLatch relayLatchChk #(.SET_DOM(SET_DOM)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .setIn    (setIn),
  .rstIn    (rstIn),
  .togMode  (togMode),
  .latchQ   (latchQ),
  .edgePulse(edgePulse)
);

// File: tb/relayLatch_tb.sv
`timescale 1ns/1ps
module relayLatch_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic setIn = 1'b0, rstIn = 1'b0, togIn = 1'b0, togMode = 1'b0;
  logic qA, eA, qB, eB, qC, eC;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  // A: reset-dominant, rising edge, pickup of 3 strobes
  relayLatch #(.SET_DOM(1'b0), .FALL_EDGE(1'b0), .PICKUP_TICKS(3)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .setIn(setIn), .rstIn(rstIn),
    .togIn(togIn), .togMode(togMode), .latchQ(qA), .edgePulse(eA));
  // B: set-dominant, rising edge, no pickup
  relayLatch #(.SET_DOM(1'b1), .FALL_EDGE(1'b0), .PICKUP_TICKS(1)) u_dutSet (
    .clk(clk), .rst(rst), .tick(tick), .setIn(setIn), .rstIn(rstIn),
    .togIn(togIn), .togMode(togMode), .latchQ(qB), .edgePulse(eB));
  // C: reset-dominant, falling edge, no pickup
  relayLatch #(.SET_DOM(1'b0), .FALL_EDGE(1'b1), .PICKUP_TICKS(1)) u_dutFall (
    .clk(clk), .rst(rst), .tick(tick), .setIn(setIn), .rstIn(rstIn),
    .togIn(togIn), .togMode(togMode), .latchQ(qC), .edgePulse(eC));

  // {setIn,rstIn,togIn,togMode, qA,eA, qB,eB, qC,eC} after one strobe
  localparam int NVEC = 17;
  localparam logic [9:0] VEC [NVEC] = '{
    10'b1000_10_10_10,  // R3 R4 set
    10'b1100_00_10_00,  // R3 reset wins, R4 set wins
    10'b0000_00_10_00,  // R3 R4 hold
    10'b0100_00_00_00,  // R4 reset alone
    10'b1010_10_11_10,  // R5 toggle input in latch mode, pulse on B
    10'b0000_10_10_11,  // R9 falling edge on C
    10'b0011_10_01_10,  // R6 B flips, R8 A still picking up
    10'b0011_10_00_10,  // R7 pulse gone after one interval
    10'b1111_01_00_10,  // R8 A qualifies at third sample, R6 set/reset ignored
    10'b0011_00_00_10,  // R6 level held, no edge
    10'b0001_00_00_01,  // R9 C flips on falling edge
    10'b0011_00_11_00,  // R8 single sample not enough for A
    10'b0001_00_10_11,  // R8 dropout resets run
    10'b0011_00_01_10,  // R8 run restarts
    10'b0011_00_00_10,  // R8 two samples
    10'b0011_11_00_10,  // R8 third sample flips A
    10'b0010_10_00_10   // R5 back to latch mode, toggle input no effect
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic strobe(input logic s, input logic r, input logic t, input logic m);
    setIn = s; rstIn = r; togIn = t; togMode = m; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset qA", qA, 1'b0);
    chk("R1 reset eA", eA, 1'b0);
    chk("R1 reset qB", qB, 1'b0);
    chk("R1 reset qC", qC, 1'b0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      strobe(VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6]);
      chk($sformatf("vec%0d qA R3/R5/R6/R8", i), qA, VEC[i][5]);
      chk($sformatf("vec%0d eA R7/R8", i), eA, VEC[i][4]);
      chk($sformatf("vec%0d qB R4/R6", i), qB, VEC[i][3]);
      chk($sformatf("vec%0d eB R7", i), eB, VEC[i][2]);
      chk($sformatf("vec%0d qC R3/R9", i), qC, VEC[i][1]);
      chk($sformatf("vec%0d eC R9", i), eC, VEC[i][0]);
    end

    // R2: no update without a strobe (A=1, B=0, C=1 now)
    setIn = 1'b0; rstIn = 1'b1; togIn = 1'b0; togMode = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R2 hold qA", qA, 1'b1);
      chk("R2 hold qC", qC, 1'b1);
    end
    strobe(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R3 strobe reset qA", qA, 1'b0);
    chk("R3 strobe reset qC", qC, 1'b0);
    chk("R9 falling pulse eC", eC, 1'b1);
    chk("R5 no pulse eA", eA, 1'b0);
    // R7: pulse spans the whole interval
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R7 pulse held eC", eC, 1'b1);
    end
    strobe(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R7 pulse ends eC", eC, 1'b0);

    // R1: reset clears history; first strobe with toggle high is an edge
    setIn = 1'b0; rstIn = 1'b0; togIn = 1'b1; togMode = 1'b1;
    strobe(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R6 pre-reset flip qB", qB, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 mid reset qB", qB, 1'b0);
    chk("R1 mid reset eB", eB, 1'b0);
    strobe(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R1 history cleared eB", eB, 1'b1);
    chk("R1 history cleared qB", qB, 1'b1);
    chk("R8 count cleared qA", qA, 1'b0);
    chk("R9 no falling edge qC", qC, 1'b0);

    finishRun();
  end

endmodule